// File: doc/BRIEF.md
# PWM Generator with Shutdown and Recall

This block turns a 5-bit duty code into a pulse-width waveform with a period of 32 ticks. A free-running 5-bit counter moves forward on each clock cycle in which the tick input is high. The output is high while the counter is below the active duty code. This gives high times from 0 to 31/32 of the period in steps of 1/32. A separate full-on mode holds the output high for the whole period.

A shutdown mode releases the output pin: the output enable for a tristate pad goes low and the counter stops. A later recall leaves shutdown and restores the exact setting that was in force before, both the duty and full-on. The counter then starts again from zero. A new duty code waits for the next counter wrap before it takes effect, so a period is never cut short.

Commands arrive as a one-cycle write strobe that carries a 3-bit mode code and a 5-bit duty code. An 8-bit status word reports the shutdown flag, the full-on flag and the stored duty code, for read-back.

Top module: `pwm_shutdown_gen`

## Requirements
- R1: After reset, pwm_o is 0, pwm_oe_o is 1 and status_o is 0.
- R2: With mode normal and tick high every cycle, any 32 consecutive ticks that start one full period after a duty write give exactly duty_i cycles with pwm_o high.
- R3: Duty code 0 keeps pwm_o low for the whole period. Duty code 31 gives exactly one low tick per 32.
- R4: A write with mode 001 (full-on) drives pwm_o high on every cycle, whatever the duty code, and sets status_o[6]. The duty field of status is left unchanged.
- R5: A write with mode 000 (normal) stores duty_i in status_o[4:0] and clears full-on.
- R6: A write with mode 010 (shutdown) drives pwm_oe_o low and pwm_o low, and sets status_o[7]. The counter holds.
- R7: A write with mode 011 (recall) while shut down clears status_o[7] and restores the prior duty and full-on. The counter restarts from zero, so the first duty ticks after recall are high.
- R8: A duty change lets the period in progress finish with the old code. The new code applies from the next counter wrap.
- R9: A write with a mode code whose top bit is 1 (100 to 111) changes neither status_o nor the waveform.
- R10: While shut down, normal and full-on writes are ignored. Only recall is accepted.
- R11: The counter advances only on cycles with tick_i high. With tick_i low, pwm_o holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter advance enable; sets the PWM period |
| wr_i | input | 1 | Command write strobe |
| mode_i | input | 3 | Mode code: 000 normal, 001 full-on, 010 shutdown, 011 recall |
| duty_i | input | 5 | Duty code used by a normal write |
| pwm_o | output | 1 | PWM level (driven low while released) |
| pwm_oe_o | output | 1 | Output enable for the tristate pad |
| status_o | output | 8 | {shutdown, full-on, 0, stored duty} |

## Verification
The bench first zeroes the counter's phase with a shutdown and recall pair. It then changes the duty in the middle of a period. A design that latched the duty immediately would cut the running period short at the new code. It checks that recall starts counting from zero and brings back full-on. A design that kept the old count, or dropped the full-on flag, would start with the wrong level. It writes reserved mode codes and sends normal or full-on writes during shutdown; a design that decoded only the low mode bits, or accepted writes while released, would change status. It stops the tick and checks that the level holds, to catch a counter that runs freely. Duty codes 0 and 31 are measured by counting high cycles over a whole period.

// File: rtl/pwm_sr_pkg.sv
package pwm_sr_pkg;
  localparam int DUTY_W_DEF = 5;
  localparam int MODE_W     = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL   = 3'b000,
    MODE_FULL_ON  = 3'b001,
    MODE_SHUTDOWN = 3'b010,
    MODE_RECALL   = 3'b011
  } mode_e;

  // Codes with the top bit set are reserved.
  function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
    return m[MODE_W-1];
  endfunction
endpackage

// File: rtl/pwm_sr_cmd.sv
module pwm_sr_cmd
  import pwm_sr_pkg::*;
#(
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] cfg_duty_o,
  output logic              full_on_o,
  output logic              shut_o,
  output logic              recall_ev_o
);
  logic [DUTY_W-1:0] duty_q;
  logic full_q, shut_q;

  // Named events for the assertions and the counter.
  logic take_normal, take_full, take_shut, recall_ev, ignored_wr, blocked_wr;
  assign ignored_wr  = wr_i && mode_reserved(mode_i);
  assign take_normal = wr_i && !shut_q && (mode_i == MODE_NORMAL);
  assign take_full   = wr_i && !shut_q && (mode_i == MODE_FULL_ON);
  assign take_shut   = wr_i && !shut_q && (mode_i == MODE_SHUTDOWN);
  assign recall_ev   = wr_i &&  shut_q && (mode_i == MODE_RECALL);
  assign blocked_wr  = wr_i &&  shut_q && (mode_i != MODE_RECALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      full_q <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      if (take_normal) begin
        duty_q <= duty_i;
        full_q <= 1'b0;
      end
      if (take_full) full_q <= 1'b1;
      if (take_shut) shut_q <= 1'b1;
      if (recall_ev) shut_q <= 1'b0;
    end
  end

  assign cfg_duty_o  = duty_q;
  assign full_on_o   = full_q;
  assign shut_o      = shut_q;
  assign recall_ev_o = recall_ev;

  assert_reserved_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignored_wr |=> $stable({duty_q, full_q, shut_q}));

  assert_locked_in_shutdown_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_wr |=> (shut_q && $stable({duty_q, full_q})));
endmodule

// File: rtl/pwm_sr_period.sv
module pwm_sr_period
  import pwm_sr_pkg::*;
#(
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [DUTY_W-1:0] next_duty_i,
  output logic [DUTY_W-1:0] cnt_o,
  output logic [DUTY_W-1:0] act_duty_o
);
  localparam logic [DUTY_W-1:0] CNT_LAST = {DUTY_W{1'b1}};

  logic [DUTY_W-1:0] cnt_q, act_q;
  logic step_ev, wrap_ev;
  assign step_ev = tick_i && run_i;
  assign wrap_ev = step_ev && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
      act_q <= next_duty_i;
    end else if (step_ev) begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap_ev) act_q <= next_duty_i;
    end
  end

  assign cnt_o      = cnt_q;
  assign act_duty_o = act_q;

  assert_hold_without_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !step_ev) |=> $stable(cnt_q));

  assert_restart_from_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));

  assert_duty_only_at_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !wrap_ev) |=> $stable(act_q));

  assert_wrap_to_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_ev && !restart_i) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_sr_drive.sv
module pwm_sr_drive
  import pwm_sr_pkg::*;
#(
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] cnt_i,
  input  logic [DUTY_W-1:0] act_duty_i,
  input  logic              full_on_i,
  input  logic              shut_i,
  output logic              pwm_o,
  output logic              oe_o
);
  function automatic logic in_high_phase(input logic [DUTY_W-1:0] c,
                                         input logic [DUTY_W-1:0] d);
    return c < d;
  endfunction

  assign oe_o  = !shut_i;
  assign pwm_o = !shut_i && (full_on_i || in_high_phase(cnt_i, act_duty_i));

  assert_quiet_while_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shut_i && $stable(shut_i)) |-> (!pwm_o && !oe_o && $stable(cnt_i)));
endmodule

// File: rtl/pwm_shutdown_gen.sv
module pwm_shutdown_gen
  import pwm_sr_pkg::*;
#(
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                wr_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [DUTY_W-1:0]   duty_i,
  output logic                pwm_o,
  output logic                pwm_oe_o,
  output logic [DUTY_W+2:0]   status_o
);
  logic [DUTY_W-1:0] cfg_duty, cnt, act_duty;
  logic full_on, shut, recall_ev;

  pwm_sr_cmd #(.DUTY_W(DUTY_W)) cmd_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .mode_i(mode_i), .duty_i(duty_i),
    .cfg_duty_o(cfg_duty), .full_on_o(full_on), .shut_o(shut), .recall_ev_o(recall_ev)
  );

  pwm_sr_period #(.DUTY_W(DUTY_W)) period_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .run_i(!shut),
    .restart_i(recall_ev), .next_duty_i(cfg_duty),
    .cnt_o(cnt), .act_duty_o(act_duty)
  );

  pwm_sr_drive #(.DUTY_W(DUTY_W)) drive_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .act_duty_i(act_duty),
    .full_on_i(full_on), .shut_i(shut), .pwm_o(pwm_o), .oe_o(pwm_oe_o)
  );

  assign status_o = {shut, full_on, 1'b0, cfg_duty};

  assert_recall_drives_pad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_ev |=> (pwm_oe_o && (pwm_o == (full_on || (cfg_duty != '0)))));

  assert_full_on_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !shut && mode_i == MODE_FULL_ON) |=> pwm_o);
endmodule

// File: tb/pwm_shutdown_gen_tb_top.sv
module pwm_shutdown_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [4:0] duty = 5'd0;
  logic pwm, oe;
  logic [7:0] status;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_shutdown_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .mode_i(mode),
    .duty_i(duty), .pwm_o(pwm), .pwm_oe_o(oe), .status_o(status)
  );

  typedef struct packed { logic pwm; logic oe; logic [7:0] st; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  function automatic logic [7:0] st_word(bit sd, bit fo, int d);
    return {sd, fo, 1'b0, d[4:0]};
  endfunction

  task automatic push(bit p, bit e, logic [7:0] s, string tag);
    exp_q.push_back('{pwm: p, oe: e, st: s});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (pwm !== e.pwm || oe !== e.oe || status !== e.st) begin
        n_bad++;
        $display("FAIL %s: got pwm=%b oe=%b st=%h, want pwm=%b oe=%b st=%h",
                 t, pwm, oe, status, e.pwm, e.oe, e.st);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic write(logic [2:0] m, logic [4:0] d);
    wr = 1'b1; mode = m; duty = d;
    cyc();
    wr = 1'b0; mode = 3'b000; duty = 5'd0;
  endtask

  task automatic chk(bit ok, string tag, int act, int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d, want %0d", tag, act, expv);
    end
  endtask

  // Count high cycles over one period after letting a full period settle.
  task automatic measure(int d, string tag);
    int hi = 0;
    repeat (32) cyc();
    for (int i = 0; i < 32; i++) begin
      if (pwm === 1'b1) hi++;
      cyc();
    end
    chk(hi == d, tag, hi, d);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    push(1'b0, 1'b1, 8'h00, "R1 reset state");
    cyc();
    tick = 1'b1;

    // R2 duty ratio
    write(3'b000, 5'd17); measure(17, "R2 duty 17");
    write(3'b000, 5'd1);  measure(1,  "R2 duty 1");
    // R3 extremes
    write(3'b000, 5'd0);  measure(0,  "R3 duty 0");
    write(3'b000, 5'd31); measure(31, "R3 duty 31");

    // R4 full-on
    write(3'b001, 5'd3);
    for (int k = 0; k < 32; k++) begin
      push(1'b1, 1'b1, st_word(0, 1, 31), "R4 full-on high");
      cyc();
    end

    // R5 normal clears full-on
    write(3'b000, 5'd8);
    push(1'b1, 1'b1, st_word(0, 0, 8), "R5 status after normal");
    cyc();
    measure(8, "R5 duty 8 after full-on");

    // R6 shutdown
    write(3'b010, 5'd0);
    for (int k = 0; k < 40; k++) begin
      push(1'b0, 1'b0, st_word(1, 0, 8), "R6 released");
      cyc();
    end

    // R10 writes ignored in shutdown
    write(3'b000, 5'd3);
    write(3'b001, 5'd0);
    push(1'b0, 1'b0, st_word(1, 0, 8), "R10 locked in shutdown");
    cyc();

    // R7 recall restarts from zero with duty 8
    write(3'b011, 5'd0);
    for (int k = 0; k < 32; k++) begin
      push(k < 8, 1'b1, st_word(0, 0, 8), "R7 recall waveform");
      cyc();
    end

    // R8 mid-period change waits for wrap
    write(3'b000, 5'd20);
    repeat (40) cyc();
    write(3'b010, 5'd0);
    write(3'b011, 5'd0);
    for (int k = 0; k < 64; k++) begin
      bit p;
      p = (k < 32) ? (k < 20) : ((k - 32) < 6);
      push(p, 1'b1, st_word(0, 0, (k <= 10) ? 20 : 6), "R8 duty latched at wrap");
      if (k == 10) begin wr = 1'b1; mode = 3'b000; duty = 5'd6; end
      cyc();
      wr = 1'b0; mode = 3'b000; duty = 5'd0;
    end

    // R7 recall restores full-on
    write(3'b001, 5'd0);
    write(3'b010, 5'd0);
    push(1'b0, 1'b0, st_word(1, 1, 6), "R7 shut with full-on");
    cyc();
    write(3'b011, 5'd0);
    for (int k = 0; k < 40; k++) begin
      push(1'b1, 1'b1, st_word(0, 1, 6), "R7 full-on restored");
      cyc();
    end

    // R9 reserved codes
    write(3'b000, 5'd12);
    repeat (40) cyc();
    write(3'b101, 5'd2);
    write(3'b111, 5'd31);
    write(3'b100, 5'd0);
    push(pwm, 1'b1, st_word(0, 0, 12), "R9 reserved ignored");
    cyc();
    measure(12, "R9 waveform unchanged");

    // R11 tick gating
    write(3'b010, 5'd0);
    tick = 1'b0;
    write(3'b011, 5'd0);
    for (int k = 0; k < 20; k++) begin
      push(1'b1, 1'b1, st_word(0, 0, 12), "R11 held without tick");
      cyc();
    end
    tick = 1'b1;
    for (int k = 0; k < 32; k++) begin
      push(k < 12, 1'b1, st_word(0, 0, 12), "R11 resumes from zero");
      cyc();
    end

    cyc();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule